// File: doc/BRIEF.md
# Programmable Sensor Sync Timing Generator

This block produces the raster timing for a raw image sensor. It runs on the pixel clock. A column counter and a row counter scan a frame whose line length and row count can be programmed. From their position it derives horizontal sync, vertical sync, a blanking signal, a row-windowed flash strobe, and the row and column coordinates of the pixel in the active window. Each of the four strobes has its own polarity bit. A mirror bit reverses the column coordinate inside the active window.

All timing parameters arrive on plain configuration inputs. They are not used directly. A one-cycle update request snapshots them into a staging copy and arms a small two-state controller: `UPD_IDLE` goes to `UPD_ARMED` on a request. While armed, `upd_busy` reads 1. On the last pixel of the current frame, the transition `UPD_ARMED` to `UPD_IDLE` (or back to `UPD_ARMED` if a new request arrives in that same cycle) copies the staging set into the active set. Every parameter therefore switches on the same edge on which both counters wrap to zero.

Top module: `sync_timing_gen`

## Requirements
- R1: After reset, the active and staging parameters equal the reset parameters. Defaults are: line length 500, frame rows 400, column start 100, row start 10, HSYNC end 64, VSYNC end 3, flash rows 298 to 318, all polarities 0 (active low), mirror off. After reset the counters are at row 0, column 0 and `upd_busy` is 0.
- R2: The column counter runs from 0 to line length − 1. When it wraps, the row counter advances. The row counter runs from 0 to frame rows − 1 and then wraps to 0.
- R3: HSYNC is asserted while the column is below the HSYNC end value.
- R4: VSYNC is asserted while the row is below the VSYNC end value.
- R5: FLASH is asserted while the row is at or above the flash begin row and below the flash end row.
- R6: The active window covers ACT_COLS (352) columns from the column start and ACT_ROWS rows from the row start. Inside it, `pix_valid` is 1 and `pix_row` is the row minus the row start. Outside it, `pix_valid`, `pix_col` and `pix_row` are all 0.
- R7: BLANK is asserted exactly when the current position lies outside the active window.
- R8: For each strobe, polarity bit 1 drives the pin 1 when the strobe is asserted. Polarity bit 0 drives the pin 0 when the strobe is asserted.
- R9: With mirror 0, `pix_col` is the column minus the column start. With mirror 1, it is ACT_COLS − 1 minus that difference, so it runs from 351 down to 0.
- R10: A cycle with `upd_req` high captures every configuration input into staging, and `upd_busy` is 1 from the next cycle. Configuration inputs changed later, without a new request, have no effect.
- R11: Staged values take effect only on the edge where both counters wrap to zero. `upd_busy` clears on that same edge, and the rest of the current frame keeps the old parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_line_len | input | 10 | Pixel clocks per line |
| cfg_frame_rows | input | 16 | Rows per frame |
| cfg_col_start | input | 10 | First active column |
| cfg_row_start | input | 16 | First active row |
| cfg_hs_end | input | 10 | Column at which HSYNC ends |
| cfg_vs_end | input | 16 | Row at which VSYNC ends |
| cfg_flash_begin | input | 16 | First flash row |
| cfg_flash_end | input | 16 | Row at which flash ends |
| cfg_pol_hs | input | 1 | HSYNC polarity, 1 = active high |
| cfg_pol_vs | input | 1 | VSYNC polarity, 1 = active high |
| cfg_pol_flash | input | 1 | FLASH polarity, 1 = active high |
| cfg_pol_blank | input | 1 | BLANK polarity, 1 = active high |
| cfg_mirror | input | 1 | Reverse active column coordinate |
| upd_req | input | 1 | One-cycle request to stage and arm an update |
| upd_busy | output | 1 | 1 while a staged update waits for the frame boundary |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Outside-window indication |
| flash | output | 1 | Flash strobe |
| pix_valid | output | 1 | Current position is inside the active window |
| pix_col | output | 10 | Active column coordinate |
| pix_row | output | 16 | Active row coordinate |

## Verification
Some properties are checked on every cycle:
- counters stay inside the programmed line length;
- the row steps and both counters wrap on the last pixel;
- a request always arms the controller;
- the active set cannot move while armed except on the wrap edge, and busy only falls on that edge;
- coordinates stay inside the window and are zero outside it.

Other behaviour only the directed scenarios can show:
- the exact columns and rows where each strobe toggles;
- the effect of each polarity bit and of mirroring;
- staging inputs being ignored after the request;
- a shorter line and frame taking hold precisely at the next frame start.

// File: rtl/sync_timing_pkg.sv
package sync_timing_pkg;

    localparam int COL_W = 10;
    localparam int ROW_W = 16;

    typedef struct packed {
        logic [COL_W-1:0] line_len;
        logic [COL_W-1:0] col_start;
        logic [COL_W-1:0] hs_end;
        logic [ROW_W-1:0] frame_rows;
        logic [ROW_W-1:0] row_start;
        logic [ROW_W-1:0] vs_end;
        logic [ROW_W-1:0] flash_begin;
        logic [ROW_W-1:0] flash_end;
        logic             pol_hs;
        logic             pol_vs;
        logic             pol_flash;
        logic             pol_blank;
        logic             mirror;
    } tcfg_t;

    typedef enum logic [0:0] {
        UPD_IDLE  = 1'b0,
        UPD_ARMED = 1'b1
    } upd_state_t;

endpackage

// File: rtl/sync_shadow_ctrl.sv
module sync_shadow_ctrl
    import sync_timing_pkg::*;
#(
    parameter tcfg_t RST_CFG = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  upd_req,
    input  tcfg_t stage_in,
    input  logic  frame_wrap,
    output tcfg_t act_cfg,
    output logic  busy
);

    upd_state_t state_q, state_d;
    logic       load;
    tcfg_t      stage_q;
    tcfg_t      act_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    // next state and transfer strobe
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            UPD_IDLE: begin
                if (upd_req) state_d = UPD_ARMED;
            end
            UPD_ARMED: begin
                if (frame_wrap) begin
                    load    = 1'b1;
                    state_d = upd_req ? UPD_ARMED : UPD_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stage_q <= RST_CFG;
        else if (upd_req) stage_q <= stage_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    act_q <= RST_CFG;
        else if (load) act_q <= stage_q;
    end

    assign act_cfg = act_q;
    assign busy    = (state_q == UPD_ARMED);

    // R10
    req_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |=> busy);

    // R11
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_wrap) |=> $stable(act_q));

    // R11
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(frame_wrap));

endmodule

// File: rtl/sync_raster_cnt.sv
module sync_raster_cnt #(
    parameter int COL_W = 10,
    parameter int ROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] line_len,
    input  logic [ROW_W-1:0] frame_rows,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic             frame_wrap
);

    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic             col_last;
    logic             row_last;

    assign col_last   = (col_q == line_len - 1'b1);
    assign row_last   = (row_q == frame_rows - 1'b1);
    assign frame_wrap = col_last && row_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (col_last) begin
            col_q <= '0;
            row_q <= row_last ? '0 : row_q + 1'b1;
        end else begin
            col_q <= col_q + 1'b1;
        end
    end

    assign col = col_q;
    assign row = row_q;

    // R2
    col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_q < line_len);

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (col_q == '0 && row_q == '0));

    // R2
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !row_last) |=> (col_q == '0 && row_q == $past(row_q) + 1'b1));

endmodule

// File: rtl/sync_out_decode.sv
module sync_out_decode
    import sync_timing_pkg::*;
#(
    parameter int ACT_COLS = 352,
    parameter int ACT_ROWS = 288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  tcfg_t            cfg,
    output logic             hsync,
    output logic             vsync,
    output logic             flash,
    output logic             blank,
    output logic             pix_valid,
    output logic [COL_W-1:0] pix_col,
    output logic [ROW_W-1:0] pix_row
);

    localparam logic [COL_W:0]   COL_SPAN = (COL_W+1)'(ACT_COLS);
    localparam logic [ROW_W:0]   ROW_SPAN = (ROW_W+1)'(ACT_ROWS);
    localparam logic [COL_W-1:0] COL_TOP  = COL_W'(ACT_COLS - 1);

    logic [COL_W:0]   col_x, col_lo, col_hi;
    logic [ROW_W:0]   row_x, row_lo, row_hi;
    logic             in_col, in_row, active;
    logic             hs_act, vs_act, fl_act;
    logic [COL_W-1:0] rel_col;
    logic [ROW_W-1:0] rel_row;

    always_comb begin
        col_x   = {1'b0, col};
        col_lo  = {1'b0, cfg.col_start};
        col_hi  = col_lo + COL_SPAN;
        row_x   = {1'b0, row};
        row_lo  = {1'b0, cfg.row_start};
        row_hi  = row_lo + ROW_SPAN;
        in_col  = (col_x >= col_lo) && (col_x < col_hi);
        in_row  = (row_x >= row_lo) && (row_x < row_hi);
        active  = in_col && in_row;
        rel_col = col - cfg.col_start;
        rel_row = row - cfg.row_start;
        hs_act  = (col < cfg.hs_end);
        vs_act  = (row < cfg.vs_end);
        fl_act  = (row >= cfg.flash_begin) && (row < cfg.flash_end);
    end

    always_comb begin
        hsync     = ~(hs_act ^ cfg.pol_hs);
        vsync     = ~(vs_act ^ cfg.pol_vs);
        flash     = ~(fl_act ^ cfg.pol_flash);
        blank     = ~((!active) ^ cfg.pol_blank);
        pix_valid = active;
        pix_col   = '0;
        pix_row   = '0;
        if (active) begin
            pix_col = cfg.mirror ? (COL_TOP - rel_col) : rel_col;
            pix_row = rel_row;
        end
    end

    // R6
    coord_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_col < COL_W'(ACT_COLS) && pix_row < ROW_W'(ACT_ROWS)));

    // R6
    coord_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> (pix_col == '0 && pix_row == '0));

endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
    import sync_timing_pkg::*;
#(
    parameter int   ACT_COLS        = 352,
    parameter int   ACT_ROWS        = 288,
    parameter int   RST_LINE_LEN    = 500,
    parameter int   RST_FRAME_ROWS  = 400,
    parameter int   RST_COL_START   = 100,
    parameter int   RST_ROW_START   = 10,
    parameter int   RST_HS_END      = 64,
    parameter int   RST_VS_END      = 3,
    parameter int   RST_FLASH_BEGIN = 298,
    parameter int   RST_FLASH_END   = 318,
    parameter logic RST_POL_HS      = 1'b0,
    parameter logic RST_POL_VS      = 1'b0,
    parameter logic RST_POL_FLASH   = 1'b0,
    parameter logic RST_POL_BLANK   = 1'b0,
    parameter logic RST_MIRROR      = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] cfg_line_len,
    input  logic [ROW_W-1:0] cfg_frame_rows,
    input  logic [COL_W-1:0] cfg_col_start,
    input  logic [ROW_W-1:0] cfg_row_start,
    input  logic [COL_W-1:0] cfg_hs_end,
    input  logic [ROW_W-1:0] cfg_vs_end,
    input  logic [ROW_W-1:0] cfg_flash_begin,
    input  logic [ROW_W-1:0] cfg_flash_end,
    input  logic             cfg_pol_hs,
    input  logic             cfg_pol_vs,
    input  logic             cfg_pol_flash,
    input  logic             cfg_pol_blank,
    input  logic             cfg_mirror,
    input  logic             upd_req,
    output logic             upd_busy,
    output logic             hsync,
    output logic             vsync,
    output logic             blank,
    output logic             flash,
    output logic             pix_valid,
    output logic [COL_W-1:0] pix_col,
    output logic [ROW_W-1:0] pix_row
);

    localparam tcfg_t RST_CFG = '{
        line_len:    COL_W'(RST_LINE_LEN),
        col_start:   COL_W'(RST_COL_START),
        hs_end:      COL_W'(RST_HS_END),
        frame_rows:  ROW_W'(RST_FRAME_ROWS),
        row_start:   ROW_W'(RST_ROW_START),
        vs_end:      ROW_W'(RST_VS_END),
        flash_begin: ROW_W'(RST_FLASH_BEGIN),
        flash_end:   ROW_W'(RST_FLASH_END),
        pol_hs:      RST_POL_HS,
        pol_vs:      RST_POL_VS,
        pol_flash:   RST_POL_FLASH,
        pol_blank:   RST_POL_BLANK,
        mirror:      RST_MIRROR
    };

    tcfg_t            stage_in;
    tcfg_t            act_cfg;
    logic             frame_wrap;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;

    always_comb begin
        stage_in.line_len    = cfg_line_len;
        stage_in.col_start   = cfg_col_start;
        stage_in.hs_end      = cfg_hs_end;
        stage_in.frame_rows  = cfg_frame_rows;
        stage_in.row_start   = cfg_row_start;
        stage_in.vs_end      = cfg_vs_end;
        stage_in.flash_begin = cfg_flash_begin;
        stage_in.flash_end   = cfg_flash_end;
        stage_in.pol_hs      = cfg_pol_hs;
        stage_in.pol_vs      = cfg_pol_vs;
        stage_in.pol_flash   = cfg_pol_flash;
        stage_in.pol_blank   = cfg_pol_blank;
        stage_in.mirror      = cfg_mirror;
    end

    sync_shadow_ctrl #(
        .RST_CFG (RST_CFG)
    ) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_req    (upd_req),
        .stage_in   (stage_in),
        .frame_wrap (frame_wrap),
        .act_cfg    (act_cfg),
        .busy       (upd_busy)
    );

    sync_raster_cnt #(
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_len   (act_cfg.line_len),
        .frame_rows (act_cfg.frame_rows),
        .col        (col),
        .row        (row),
        .frame_wrap (frame_wrap)
    );

    sync_out_decode #(
        .ACT_COLS (ACT_COLS),
        .ACT_ROWS (ACT_ROWS)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .col       (col),
        .row       (row),
        .cfg       (act_cfg),
        .hsync     (hsync),
        .vsync     (vsync),
        .flash     (flash),
        .blank     (blank),
        .pix_valid (pix_valid),
        .pix_col   (pix_col),
        .pix_row   (pix_row)
    );

endmodule

// File: tb/sim_sync_timing_gen.sv
module sim_sync_timing_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  cfg_line_len = 10'd500;
    logic [15:0] cfg_frame_rows = 16'd12;
    logic [9:0]  cfg_col_start = 10'd100;
    logic [15:0] cfg_row_start = 16'd2;
    logic [9:0]  cfg_hs_end = 10'd64;
    logic [15:0] cfg_vs_end = 16'd1;
    logic [15:0] cfg_flash_begin = 16'd5;
    logic [15:0] cfg_flash_end = 16'd7;
    logic        cfg_pol_hs = 1'b0;
    logic        cfg_pol_vs = 1'b0;
    logic        cfg_pol_flash = 1'b0;
    logic        cfg_pol_blank = 1'b0;
    logic        cfg_mirror = 1'b0;
    logic        upd_req = 1'b0;
    logic        upd_busy, hsync, vsync, blank, flash, pix_valid;
    logic [9:0]  pix_col;
    logic [15:0] pix_row;

    int n_tests = 0;
    int n_fail  = 0;

    // bench position model: line and frame lengths as the requirements define
    int m_col, m_row, m_len, m_rows, s_len, s_rows;
    bit m_armed;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_timing_gen #(
        .ACT_ROWS        (4),
        .RST_FRAME_ROWS  (12),
        .RST_ROW_START   (2),
        .RST_VS_END      (1),
        .RST_FLASH_BEGIN (5),
        .RST_FLASH_END   (7)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_line_len(cfg_line_len), .cfg_frame_rows(cfg_frame_rows),
        .cfg_col_start(cfg_col_start), .cfg_row_start(cfg_row_start),
        .cfg_hs_end(cfg_hs_end), .cfg_vs_end(cfg_vs_end),
        .cfg_flash_begin(cfg_flash_begin), .cfg_flash_end(cfg_flash_end),
        .cfg_pol_hs(cfg_pol_hs), .cfg_pol_vs(cfg_pol_vs),
        .cfg_pol_flash(cfg_pol_flash), .cfg_pol_blank(cfg_pol_blank),
        .cfg_mirror(cfg_mirror), .upd_req(upd_req), .upd_busy(upd_busy),
        .hsync(hsync), .vsync(vsync), .blank(blank), .flash(flash),
        .pix_valid(pix_valid), .pix_col(pix_col), .pix_row(pix_row)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_col <= 0; m_row <= 0; m_len <= 500; m_rows <= 12;
            s_len <= 500; s_rows <= 12; m_armed <= 1'b0;
        end else begin
            if (m_col == m_len - 1) begin
                m_col <= 0;
                if (m_row == m_rows - 1) begin
                    m_row <= 0;
                    if (m_armed) begin
                        m_len <= s_len; m_rows <= s_rows; m_armed <= 1'b0;
                    end
                end else begin
                    m_row <= m_row + 1;
                end
            end else begin
                m_col <= m_col + 1;
            end
            if (upd_req) begin
                s_len <= int'(cfg_line_len); s_rows <= int'(cfg_frame_rows);
                m_armed <= 1'b1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic goto(input int r, input int c);
        while (!(m_row == r && m_col == c)) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "busy after reset", upd_busy, 0);
        chk("R1", "hsync low-active asserted", hsync, 0);
        chk("R1", "vsync low-active asserted", vsync, 0);
        chk("R1", "flash idle", flash, 1);
        chk("R1", "blank asserted", blank, 0);
        chk("R1", "pix_valid", pix_valid, 0);
    endtask

    task automatic t_hsync;
        goto(0, 63);  chk("R3", "hsync col 63", hsync, 0);
        goto(0, 64);  chk("R3", "hsync col 64", hsync, 1);
        goto(0, 499); chk("R3", "hsync col 499", hsync, 1);
        goto(1, 0);   chk("R2", "hsync after line wrap", hsync, 0);
        chk("R4", "vsync row 1", vsync, 1);
    endtask

    task automatic t_window;
        goto(2, 99);  chk("R7", "blank col 99", blank, 0);
        chk("R6", "valid col 99", pix_valid, 0);
        goto(2, 100); chk("R7", "blank col 100", blank, 1);
        chk("R6", "valid col 100", pix_valid, 1);
        chk("R9", "pix_col first", pix_col, 0);
        chk("R6", "pix_row first", pix_row, 0);
        goto(3, 451); chk("R9", "pix_col last", pix_col, 351);
        chk("R6", "pix_row row 3", pix_row, 1);
        goto(3, 452); chk("R7", "blank col 452", blank, 0);
        chk("R6", "pix_col outside", pix_col, 0);
        goto(5, 200); chk("R6", "pix_row last row", pix_row, 3);
        goto(6, 200); chk("R6", "valid row 6", pix_valid, 0);
        chk("R7", "blank row 6", blank, 0);
    endtask

    task automatic t_flash_vsync;
        goto(4, 10);  chk("R5", "flash row 4", flash, 1);
        goto(5, 10);  chk("R5", "flash row 5", flash, 0);
        goto(6, 499); chk("R5", "flash row 6", flash, 0);
        goto(7, 0);   chk("R5", "flash row 7", flash, 1);
        goto(11, 499); chk("R4", "vsync row 11", vsync, 1);
        goto(0, 0);   chk("R2", "vsync after frame wrap", vsync, 0);
    endtask

    task automatic t_update;
        goto(1, 0);
        cfg_line_len = 10'd400;   cfg_frame_rows = 16'd8;
        cfg_col_start = 10'd20;   cfg_row_start = 16'd2;
        cfg_hs_end = 10'd10;      cfg_vs_end = 16'd2;
        cfg_flash_begin = 16'd1;  cfg_flash_end = 16'd3;
        cfg_pol_hs = 1'b1; cfg_pol_vs = 1'b1; cfg_pol_flash = 1'b1;
        cfg_pol_blank = 1'b1; cfg_mirror = 1'b1;
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
        chk("R10", "busy after request", upd_busy, 1);
        cfg_line_len = 10'd450;
        cfg_pol_hs = 1'b0;
        goto(3, 100); chk("R11", "old window kept", pix_valid, 1);
        chk("R11", "old orientation kept", pix_col, 0);
        goto(11, 499); chk("R11", "busy before wrap", upd_busy, 1);
        chk("R11", "old hsync polarity", hsync, 1);
        goto(0, 0);   chk("R11", "busy cleared at wrap", upd_busy, 0);
        chk("R8", "hsync active high", hsync, 1);
        chk("R8", "vsync active high", vsync, 1);
        chk("R8", "blank active high", blank, 1);
        chk("R8", "flash idle low", flash, 0);
        goto(0, 10);  chk("R3", "new hsync end", hsync, 0);
        goto(1, 0);   chk("R5", "new flash row 1", flash, 1);
        chk("R4", "new vsync row 1", vsync, 1);
        goto(2, 0);   chk("R4", "new vsync row 2", vsync, 0);
        goto(2, 20);  chk("R9", "mirror first", pix_col, 351);
        chk("R8", "blank deasserted high pol", blank, 0);
        goto(2, 371); chk("R9", "mirror last", pix_col, 0);
        goto(2, 372); chk("R6", "new window end", pix_valid, 0);
        goto(3, 0);   chk("R10", "staged line length 400 used", hsync, 1);
        chk("R5", "new flash end row 3", flash, 0);
        goto(7, 399); @(negedge clk);
        chk("R2", "row wrap at 8 vsync", vsync, 1);
        chk("R2", "row wrap at 8 hsync", hsync, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_hsync();
                t_window();
                t_flash_vsync();
                t_update();
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog R2: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule